// File: doc/BRIEF.md
# Receive Completion Watchdog Timer

This block guarantees that a received frame is eventually reported, even when its descriptor asked for the normal completion flag to be held back. Software programs an 8-bit timeout value. The timer starts when the receive engine finishes a frame with the completion flag withheld. If no later event raises the receive flag before the timeout ends, the block raises it itself. The timeout is the programmed value times 256 clock cycles, and the block does this with a single-cycle output pulse.

The receive engine sends three things: a frame-done pulse, a qualifier saying that the completion flag was suppressed for that frame, and a pulse whenever the flag is raised normally. A normal raising of the flag cancels a running timer. While the timer runs, the programmed value is held in an internal copy, so software may rewrite the register at any time. A value of zero turns the watchdog off.

Top module: `rx_flag_wdog`

## Requirements
- R1: After a synchronous reset, `reg_rd_data` reads 0 and `flag_force` is low.
- R2: Bits 7:0 of a write through `reg_wr_en`/`reg_wr_data` are stored and read back on `reg_rd_data[7:0]` in the cycle after the write. Bits 31:8 always read 0, whatever was written to them.
- R3: A cycle with `frame_done`=1 and `frame_quiet`=1 arms the timer when the watchdog is idle and the stored value N is non-zero. `flag_force` then goes high for exactly one cycle, N*256 clock edges after the edge that sampled the frame.
- R4: A `frame_done` with `frame_quiet`=0 does not arm the timer.
- R5: While the stored value is 0, no frame arms the timer and `flag_force` stays low.
- R6: `flag_norm_set`=1 on any edge while the timer runs stops it with no `flag_force` pulse. This holds even on the edge where the timeout would have ended.
- R7: A second suppressed-frame completion while the timer runs neither restarts it nor moves its deadline.
- R8: A register write while the timer runs does not change the running deadline. The new value, including 0, applies from the next arming.
- R9: A suppressed-frame completion sampled on the same edge as `flag_norm_set`=1 does not arm the timer.
- R10: After an expiry or a cancel, the timer can be armed again at any phase. Each arming restarts the ×256 prescaler and the count from zero, so the full N*256 delay applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read value |
| frame_done | input | 1 | Receive engine finished a frame (pulse) |
| frame_quiet | input | 1 | Completion flag was suppressed for the frame signalled by `frame_done` |
| flag_norm_set | input | 1 | Receive flag raised through normal completion (pulse) |
| flag_force | output | 1 | Watchdog raises the receive flag (one-cycle pulse) |

## Verification
Two functions can land on the same edge: the normal raising of the receive flag, and the timeout ending, which would fire the watchdog. The bench provokes this in two ways. It drives `flag_norm_set` exactly on the deadline edge computed by its own model, where it expects no pulse at all. It also drives the flag together with a suppressed frame while idle, where it expects the timer to stay unarmed. A behavioural model tracks the deadline as an absolute edge number and is compared against `flag_force` and the read value on every cycle. Directed checks confirm the exact pulse edge after re-arming, after mid-run writes and after duplicate frames.

// File: rtl/rxwd_pkg.sv
package rxwd_pkg;
    localparam int REG_W = 32;
    localparam int CFG_W = 8;
    localparam int PRE_W = 8;

    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic arm;
        logic cancel;
        logic expire;
    } wd_ctl_t;

    function automatic logic cfg_enabled(input logic [CFG_W-1:0] v);
        return v != '0;
    endfunction
endpackage

// File: rtl/rxwd_cfg_reg.sv
module rxwd_cfg_reg #(
    parameter int REG_W = rxwd_pkg::REG_W,
    parameter int CNT_W = rxwd_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [CNT_W-1:0] cfg,
    output logic [REG_W-1:0] rd_data
);
    localparam int PAD_W = REG_W - CNT_W;

    logic unused_hi;
    assign unused_hi = ^wr_data[REG_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= wr_data[CNT_W-1:0];
    end

    assign rd_data = {{PAD_W{1'b0}}, cfg};

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cfg == $past(wr_data[CNT_W-1:0]));
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));
endmodule

// File: rtl/rxwd_prescale.sv
module rxwd_prescale #(
    parameter int PRE_W = rxwd_pkg::PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || restart) pre <= '0;
        else if (run)       pre <= pre + PRE_W'(1);
    end

    assign tick = run && (pre == {PRE_W{1'b1}});

    assert_restart_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(pre));
endmodule

// File: rtl/rxwd_tick_cnt.sv
module rxwd_tick_cnt #(
    parameter int CNT_W = rxwd_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim <= '0;
            cnt <= '0;
        end else if (load) begin
            lim <= limit_in;
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign expire = tick && (cnt == lim - CNT_W'(1));

    assert_limit_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(lim));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: rtl/rx_flag_wdog.sv
module rx_flag_wdog #(
    parameter int REG_W = rxwd_pkg::REG_W,
    parameter int CNT_W = rxwd_pkg::CFG_W,
    parameter int PRE_W = rxwd_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             frame_done,
    input  logic             frame_quiet,
    input  logic             flag_norm_set,
    output logic             flag_force
);
    import rxwd_pkg::*;

    wd_state_e        state;
    wd_ctl_t          ctl;
    logic [CNT_W-1:0] cfg;
    logic             tick;
    logic             cnt_done;

    rxwd_cfg_reg #(.REG_W(REG_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
        .cfg(cfg), .rd_data(reg_rd_data)
    );

    rxwd_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .restart(ctl.arm),
        .run(state == WD_RUN), .tick(tick)
    );

    rxwd_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(ctl.arm), .limit_in(cfg),
        .tick(tick), .expire(cnt_done)
    );

    always_comb begin
        ctl.arm    = (state == WD_IDLE) && frame_done && frame_quiet
                     && !flag_norm_set && (cfg != '0);
        ctl.cancel = (state == WD_RUN) && flag_norm_set;
        ctl.expire = (state == WD_RUN) && !flag_norm_set && cnt_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= WD_IDLE;
            flag_force <= 1'b0;
        end else begin
            flag_force <= ctl.expire;
            unique case (state)
                WD_IDLE: if (ctl.arm) state <= WD_RUN;
                WD_RUN:  if (ctl.cancel || ctl.expire) state <= WD_IDLE;
                default: state <= WD_IDLE;
            endcase
        end
    end

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        flag_force |=> !flag_force);
    assert_cancel_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (state == WD_RUN && flag_norm_set) |=> (state == WD_IDLE && !flag_force));
    assert_zero_stays_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (state == WD_IDLE && !cfg_enabled(cfg)) |=> state == WD_IDLE);
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (state == WD_RUN && frame_done && !flag_norm_set && !cnt_done) |=> state == WD_RUN);
    assert_collide_no_arm_R9: assert property (@(posedge clk) disable iff (rst)
        (state == WD_IDLE && flag_norm_set) |=> state == WD_IDLE);
    assert_plain_frame_R4: assert property (@(posedge clk) disable iff (rst)
        (state == WD_IDLE && !frame_quiet) |=> state == WD_IDLE);
endmodule

// File: tb/rx_flag_wdog_test.sv
module rx_flag_wdog_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        frame_done = 1'b0;
    logic        frame_quiet = 1'b0;
    logic        flag_norm_set = 1'b0;
    logic        flag_force;

    always #4 clk = ~clk;

    rx_flag_wdog uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .frame_done(frame_done), .frame_quiet(frame_quiet),
        .flag_norm_set(flag_norm_set), .flag_force(flag_force)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    m_cfg = 0;
    bit    m_run = 0;
    bit    m_fire = 0;
    int    m_deadline = 0;
    int    fire_cnt = 0;
    int    last_fire = -1;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference, evaluated on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cfg = 0; m_run = 0; m_fire = 0;
        end else begin
            m_fire = 0;
            if (m_run) begin
                if (flag_norm_set) m_run = 0;
                else if (cyc == m_deadline) begin m_fire = 1; m_run = 0; end
            end else if (frame_done && frame_quiet && !flag_norm_set && m_cfg != 0) begin
                m_run = 1;
                m_deadline = cyc + m_cfg * 256;
            end
            if (reg_wr_en) m_cfg = int'(reg_wr_data & 32'hFF);
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (flag_force !== m_fire || reg_rd_data !== 32'(m_cfg)) begin
                bad++;
                $display("FAIL %s cycle %0d: flag_force=%b rd=%h expected flag_force=%b rd=%h",
                         cur_req, cyc, flag_force, reg_rd_data, m_fire, m_cfg);
            end
            if (flag_force === 1'b1) begin
                fire_cnt++;
                last_fire = cyc;
            end
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: run did not finish, actual cycle=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] v);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    // drives one frame completion; returns the edge index that sampled it
    task automatic send_frame(input bit quiet, input bit norm, output int edge_idx);
        frame_done = 1'b1; frame_quiet = quiet; flag_norm_set = norm;
        @(negedge clk);
        edge_idx = cyc;
        frame_done = 1'b0; frame_quiet = 1'b0; flag_norm_set = 1'b0;
    endtask

    task automatic norm_pulse();
        flag_norm_set = 1'b1;
        @(negedge clk);
        flag_norm_set = 1'b0;
    endtask

    initial begin
        int a0;
        int a1;
        int base;
        wait_cycles(4);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        cur_req = "R1";
        chk(reg_rd_data == 0, "R1 read after reset", int'(reg_rd_data), 0);
        chk(flag_force == 0, "R1 flag after reset", int'(flag_force), 0);

        // R2: reserved bits discarded
        cur_req = "R2";
        write_cfg(32'hFFFF_FF03);
        chk(reg_rd_data == 32'h03, "R2 readback", int'(reg_rd_data), 3);

        // R4: unsuppressed frame never arms
        cur_req = "R4";
        base = fire_cnt;
        send_frame(1'b0, 1'b0, a0);
        wait_cycles(900);
        chk(fire_cnt == base, "R4 pulses after plain frame", fire_cnt - base, 0);

        // R3: exact timeout N*256
        cur_req = "R3";
        base = fire_cnt;
        send_frame(1'b1, 1'b0, a0);
        wait_cycles(3 * 256 + 5);
        chk(fire_cnt == base + 1, "R3 pulse count", fire_cnt - base, 1);
        chk(last_fire == a0 + 768, "R3 pulse edge", last_fire, a0 + 768);

        // R7: second quiet frame does not restart
        cur_req = "R7";
        base = fire_cnt;
        send_frame(1'b1, 1'b0, a0);
        wait_cycles(300);
        send_frame(1'b1, 1'b0, a1);
        wait_cycles(3 * 256);
        chk(fire_cnt == base + 1, "R7 pulse count", fire_cnt - base, 1);
        chk(last_fire == a0 + 768, "R7 deadline kept", last_fire, a0 + 768);

        // R8: write during run applies at next arming
        cur_req = "R8";
        base = fire_cnt;
        send_frame(1'b1, 1'b0, a0);
        wait_cycles(100);
        write_cfg(32'h0000_0001);
        wait_cycles(3 * 256);
        chk(last_fire == a0 + 768, "R8 running deadline unchanged", last_fire, a0 + 768);
        send_frame(1'b1, 1'b0, a1);
        wait_cycles(256 + 4);
        chk(last_fire == a1 + 256, "R8 new value on next arming", last_fire, a1 + 256);
        chk(fire_cnt == base + 2, "R8 pulse count", fire_cnt - base, 2);

        // R6: cancel mid-run
        cur_req = "R6";
        write_cfg(32'h0000_0002);
        base = fire_cnt;
        send_frame(1'b1, 1'b0, a0);
        wait_cycles(200);
        norm_pulse();
        wait_cycles(600);
        chk(fire_cnt == base, "R6 pulses after cancel", fire_cnt - base, 0);

        // R6: cancel collides with the deadline edge
        send_frame(1'b1, 1'b0, a0);
        while (cyc + 1 != a0 + 512) @(negedge clk);
        norm_pulse();
        wait_cycles(20);
        chk(fire_cnt == base, "R6 cancel at deadline", fire_cnt - base, 0);

        // R9: flag raised in the same cycle as a quiet frame
        cur_req = "R9";
        send_frame(1'b1, 1'b1, a0);
        wait_cycles(600);
        chk(fire_cnt == base, "R9 no arming on collision", fire_cnt - base, 0);

        // R10: re-arm at once after expiry, odd phase
        cur_req = "R10";
        write_cfg(32'h0000_0001);
        base = fire_cnt;
        wait_cycles(37);
        send_frame(1'b1, 1'b0, a0);
        wait_cycles(256);
        send_frame(1'b1, 1'b0, a1);
        wait_cycles(256 + 3);
        chk(a1 == a0 + 257, "R10 arm edge after expiry", a1, a0 + 257);
        chk(last_fire == a1 + 256, "R10 full delay after re-arm", last_fire, a1 + 256);
        chk(fire_cnt == base + 2, "R10 pulse count", fire_cnt - base, 2);

        // R10: re-arm after a cancel at odd phase
        send_frame(1'b1, 1'b0, a0);
        wait_cycles(91);
        norm_pulse();
        send_frame(1'b1, 1'b0, a1);
        wait_cycles(256 + 3);
        chk(last_fire == a1 + 256, "R10 fresh prescale after cancel", last_fire, a1 + 256);

        // R5 and R8: zero written while running, then disabled
        cur_req = "R5";
        write_cfg(32'h0000_0002);
        base = fire_cnt;
        send_frame(1'b1, 1'b0, a0);
        write_cfg(32'h0000_0000);
        wait_cycles(512 + 3);
        chk(last_fire == a0 + 512, "R8 zero write keeps running timer", last_fire, a0 + 512);
        send_frame(1'b1, 1'b0, a1);
        wait_cycles(700);
        chk(fire_cnt == base + 1, "R5 zero disables arming", fire_cnt - base, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule